// File: doc/BRIEF.md
# Split-Select Multiplexer Latch

This block is a three-bit data path. Each bit picks one of four candidate inputs (A, B, C, D) through a two-level tree of 2:1 selectors. Two first-level selects work independently: one picks within the A/B pair and the other picks within the C/D pair. A second-level select then chooses which pair result goes forward. All select lines are shared by every bit, and only the data inputs are separate for each bit.

The selected bit goes to a level-sensitive latch. When the close input is low the latch is transparent, so changes on data or selects reach the outputs directly. When the close input is high the latch holds the value it had when close rose. A master reset overrides everything else and clears the stored value. Each bit drives a true output and its complement. The block has no clock.

Top module: `split_sel_mux_latch`

## Requirements
- R1: With sel_pair=0 and sel_ab=0, each bit of q_true equals the matching bit of din_a while the latch is open.
- R2: With sel_pair=0 and sel_ab=1, each bit of q_true equals the matching bit of din_b while the latch is open.
- R3: With sel_pair=1 and sel_cd=0, each bit of q_true equals the matching bit of din_c while the latch is open.
- R4: With sel_pair=1 and sel_cd=1, each bit of q_true equals the matching bit of din_d while the latch is open.
- R5: While lat_close=0 and rst=0, any change on a data or select input shows up on q_true with no clock.
- R6: While lat_close=1, changes on the data and select inputs have no effect. q_true keeps the value selected just before lat_close rose.
- R7: While rst=1, q_true is all zeros and q_bar is all ones, whatever lat_close, the selects and the data are.
- R8: If rst falls while lat_close=1, q_true stays all zeros until lat_close next goes low.
- R9: q_bar is always the bitwise inverse of q_true.
- R10: Each bit follows its own data inputs. The shared selects and lat_close act on all bits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din_a | input | 3 | Candidate A, one bit per slice |
| din_b | input | 3 | Candidate B, one bit per slice |
| din_c | input | 3 | Candidate C, one bit per slice |
| din_d | input | 3 | Candidate D, one bit per slice |
| sel_ab | input | 1 | First-level select for the A/B pair (1 picks B) |
| sel_cd | input | 1 | First-level select for the C/D pair (1 picks D) |
| sel_pair | input | 1 | Second-level select (1 picks the C/D result) |
| lat_close | input | 1 | Latch hold control, high holds and low is transparent |
| rst | input | 1 | Asynchronous master reset, active high |
| q_true | output | 3 | True latched outputs |
| q_bar | output | 3 | Complement latched outputs |

## Verification
The hardest case to reach is reset released while the latch is closed. The outputs must stay cleared even though the selected data is nonzero, until the latch reopens. The stimulus reaches this case directly: it holds lat_close high, pulses rst, sets nonzero data on every candidate, and only then opens the latch. The random phase also mixes reset pulses with random hold periods so that this ordering comes up repeatedly. Data/select changes are never applied in the same step as an edge of lat_close, so the captured value is always well defined.

// File: rtl/split_sel_mux_latch_pkg.sv
package split_sel_mux_latch_pkg;
  localparam int unsigned SLICES_DEF = 3;

  typedef enum logic {
    PICK_LOW  = 1'b0,
    PICK_HIGH = 1'b1
  } pick_e;

  function automatic logic pick2(input pick_e s, input logic lo, input logic hi);
    return (s == PICK_HIGH) ? hi : lo;
  endfunction
endpackage

// File: rtl/mlx_mux_tree.sv
module mlx_mux_tree
  import split_sel_mux_latch_pkg::*;
#(
  parameter int unsigned WIDTH = SLICES_DEF
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  input  logic [WIDTH-1:0] in_d,
  input  logic             s_ab,
  input  logic             s_cd,
  input  logic             s_pair,
  output logic [WIDTH-1:0] picked
);
  logic [WIDTH-1:0] lvl_ab;
  logic [WIDTH-1:0] lvl_cd;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    always_comb begin
      lvl_ab[i] = pick2(pick_e'(s_ab), in_a[i], in_b[i]);
      lvl_cd[i] = pick2(pick_e'(s_cd), in_c[i], in_d[i]);
      picked[i] = pick2(pick_e'(s_pair), lvl_ab[i], lvl_cd[i]);
    end
  end
endmodule

// File: rtl/mlx_latch_bank.sv
module mlx_latch_bank #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] d,
  input  logic             close,
  input  logic             rst,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    always_latch begin
      if (rst) begin
        q[i] = 1'b0;
      end else if (!close) begin
        q[i] = d[i];
      end
    end
  end
endmodule

// File: rtl/mlx_diff_drive.sv
module mlx_diff_drive #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] q_in,
  output logic [WIDTH-1:0] q_t,
  output logic [WIDTH-1:0] q_c
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    assign q_t[i] = q_in[i];
    assign q_c[i] = ~q_in[i];
  end
endmodule

// File: rtl/split_sel_mux_latch.sv
module split_sel_mux_latch #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] din_a,
  input  logic [WIDTH-1:0] din_b,
  input  logic [WIDTH-1:0] din_c,
  input  logic [WIDTH-1:0] din_d,
  input  logic             sel_ab,
  input  logic             sel_cd,
  input  logic             sel_pair,
  input  logic             lat_close,
  input  logic             rst,
  output logic [WIDTH-1:0] q_true,
  output logic [WIDTH-1:0] q_bar
);
  logic [WIDTH-1:0] tree_out;
  logic [WIDTH-1:0] held;

  mlx_mux_tree #(.WIDTH(WIDTH)) u_tree (
    .in_a  (din_a),
    .in_b  (din_b),
    .in_c  (din_c),
    .in_d  (din_d),
    .s_ab  (sel_ab),
    .s_cd  (sel_cd),
    .s_pair(sel_pair),
    .picked(tree_out)
  );

  mlx_latch_bank #(.WIDTH(WIDTH)) u_lat (
    .d    (tree_out),
    .close(lat_close),
    .rst  (rst),
    .q    (held)
  );

  mlx_diff_drive #(.WIDTH(WIDTH)) u_drv (
    .q_in(held),
    .q_t (q_true),
    .q_c (q_bar)
  );
endmodule

// File: rtl/split_sel_mux_latch_chk.sv
module split_sel_mux_latch_chk #(
  parameter int unsigned WIDTH = 3
) (
  input logic [WIDTH-1:0] din_a,
  input logic [WIDTH-1:0] din_b,
  input logic [WIDTH-1:0] din_c,
  input logic [WIDTH-1:0] din_d,
  input logic             sel_ab,
  input logic             sel_cd,
  input logic             sel_pair,
  input logic             lat_close,
  input logic             rst,
  input logic [WIDTH-1:0] q_true,
  input logic [WIDTH-1:0] q_bar
);
  logic [WIDTH-1:0] ref_pick;
  logic [WIDTH-1:0] ref_held;

  always_comb begin
    if (sel_pair) ref_pick = sel_cd ? din_d : din_c;
    else          ref_pick = sel_ab ? din_b : din_a;
  end

  always_ff @(posedge lat_close or posedge rst) begin
    if (rst) ref_held <= '0;
    else     ref_held <= ref_pick;
  end

  AST_TRANSP_CAPTURE: assert property (@(posedge lat_close) disable iff (rst)
    q_true == ref_pick); // R5

  AST_HOLD_VALUE: assert property (@(negedge lat_close) disable iff (rst)
    q_true == ref_held); // R6 (R8 when reset fell while closed)

  AST_RESET_LEVEL: assert property (@(negedge rst) disable iff (1'b0)
    (q_true == '0) && (q_bar == '1)); // R7

  AST_COMPLEMENT: assert property (@(posedge lat_close) disable iff (rst)
    q_bar == ~q_true); // R9
endmodule

bind split_sel_mux_latch split_sel_mux_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .din_a(din_a), .din_b(din_b), .din_c(din_c), .din_d(din_d),
  .sel_ab(sel_ab), .sel_cd(sel_cd), .sel_pair(sel_pair),
  .lat_close(lat_close), .rst(rst), .q_true(q_true), .q_bar(q_bar)
);

// File: tb/split_sel_mux_latch_tb_top.sv
`timescale 1ns/1ps
module split_sel_mux_latch_tb_top;
  localparam int W = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] din_a = '0, din_b = '0, din_c = '0, din_d = '0;
  logic sel_ab = 0, sel_cd = 0, sel_pair = 0, lat_close = 0, rst = 1;
  logic [W-1:0] q_true, q_bar;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [W-1:0] model_q = '0;

  split_sel_mux_latch #(.WIDTH(W)) dut_i (
    .din_a(din_a), .din_b(din_b), .din_c(din_c), .din_d(din_d),
    .sel_ab(sel_ab), .sel_cd(sel_cd), .sel_pair(sel_pair),
    .lat_close(lat_close), .rst(rst), .q_true(q_true), .q_bar(q_bar)
  );

  function automatic logic [W-1:0] exp_pick(input logic [W-1:0] a, b, c, d,
                                            input logic sab, scd, sp);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = sp ? (scd ? d[i] : c[i]) : (sab ? b[i] : a[i]);
    return r;
  endfunction

  function automatic logic [W-1:0] next_model(input logic [W-1:0] cur);
    if (rst) return '0;
    if (!lat_close) return exp_pick(din_a, din_b, din_c, din_d, sel_ab, sel_cd, sel_pair);
    return cur;
  endfunction

  task automatic settle();
    model_q = next_model(model_q);
    @(negedge clk);
  endtask

  task automatic chk(input string tag);
    checks++;
    if (q_true !== model_q) begin
      failures++;
      $display("FAIL %s q_true actual=%b expected=%b", tag, q_true, model_q);
    end
    checks++;
    if (q_bar !== ~model_q) begin
      failures++;
      $display("FAIL R9 (%s) q_bar actual=%b expected=%b", tag, q_bar, ~model_q);
    end
  endtask

  task automatic set_data(input logic [W-1:0] a, b, c, d);
    @(posedge clk);
    din_a = a; din_b = b; din_c = c; din_d = d;
    settle();
  endtask

  task automatic set_sel(input logic sab, scd, sp);
    @(posedge clk);
    sel_ab = sab; sel_cd = scd; sel_pair = sp;
    settle();
  endtask

  task automatic set_close(input logic v);
    @(posedge clk);
    lat_close = v;
    settle();
  endtask

  task automatic set_rst(input logic v);
    @(posedge clk);
    rst = v;
    settle();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0101);
    // reset state
    din_a = 3'b111; din_b = 3'b111; din_c = 3'b111; din_d = 3'b111;
    settle();
    chk("R7 reset state");
    set_rst(0);
    chk("R5 open after reset");

    // R1..R4 select corners with distinct per-bit data (R10)
    set_data(3'b001, 3'b010, 3'b100, 3'b110);
    set_sel(0, 0, 0); chk("R1 pick A");
    set_sel(1, 0, 0); chk("R2 pick B");
    set_sel(1, 0, 1); chk("R3 pick C");
    set_sel(1, 1, 1); chk("R4 pick D");
    set_sel(0, 1, 0); chk("R1 pick A with sel_cd high");
    set_data(3'b101, 3'b010, 3'b100, 3'b011); chk("R10 per-bit data, R5 live change");

    // R6 hold ignores data and select changes
    set_close(1); chk("R6 close");
    set_data(3'b010, 3'b101, 3'b011, 3'b100); chk("R6 data change ignored");
    set_sel(1, 0, 1); chk("R6 select change ignored");
    set_close(0); chk("R5 reopen shows new pick");

    // R7 reset overrides open latch, R8 release while closed
    set_rst(1); chk("R7 reset while open");
    set_close(1); chk("R7 reset while closed");
    set_data(3'b111, 3'b111, 3'b111, 3'b111);
    set_rst(0); chk("R8 released while closed stays clear");
    set_sel(0, 1, 1); chk("R8 select change still clear");
    set_close(0); chk("R8 reopen takes data");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int act;
      act = $urandom_range(0, 9);
      if (act < 5)
        set_data(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
      else if (act < 7)
        set_sel(1'($urandom), 1'($urandom), 1'($urandom));
      else if (act < 9)
        set_close(~lat_close);
      else
        set_rst(~rst);
      chk(lat_close ? "R6 random" : (rst ? "R7 random" : "R5 random"));
    end
    set_rst(0);
    set_close(0);
    chk("R5 final open");

    done = 1;
    summary();
  end
endmodule